// File: doc/BRIEF.md
# Latched Sixteen-Bit Interval Timer

This block is a sixteen-bit down-counter paired with a separate sixteen-bit reload latch. A host reaches both through four byte-wide addresses. A write to the high byte of the counter loads the whole latch into the count and starts a new interval. The counter then decrements once on every cycle where the tick enable input is high.

In continuous mode the count runs down through zero, steps to all-ones, and then reloads from the latch. One period therefore lasts the latch value plus two ticks, and the timer flag is raised once per period. In one-shot mode the flag is raised only on the first zero after a load. The count keeps wrapping without any reload.

The flag is held as a level on `irq_flag` and announced by a one-cycle pulse on `flag_set`. It is cleared by a strobe, by certain register writes, or by reading the low byte of the count.

Top module: `latched_timer16`

## Requirements
- R1: A write to address 0 (count low) stores the byte into the latch low byte only. The running count is not changed by that write.
- R2: A write to address 1 (count high) stores the byte into the latch high byte, loads the full new latch into the count on the same edge, clears the flag and arms one-shot mode.
- R3: A write to address 3 (latch high) stores the latch high byte and clears the flag without touching the count. A write to address 2 (latch low) stores the latch low byte and changes nothing else.
- R4: The count decrements by exactly one on each clock edge where `tick_en` is high and is otherwise held.
- R5: In continuous mode (`cont_mode` = 1) a tick at count 0 gives 0xFFFF, and the next tick reloads the latch, so one period is latch + 2 ticks.
- R6: When a tick makes the count 0, the flag goes high on that edge and `flag_set` is high for exactly that one cycle.
- R7: Reads are combinational: address 0 gives the count low byte, 1 the count high byte, 2 the latch low byte and 3 the latch high byte. A read of address 0 clears the flag. Reads of addresses 1, 2 and 3 have no side effect.
- R8: In one-shot mode (`cont_mode` = 0) only the first zero after a count-high write raises the flag. After 0xFFFF the count keeps decrementing (to 0xFFFE) instead of reloading.
- R9: A high `flag_clr` clears the flag. When a zero event and any clear request fall on the same edge, the flag ends up set.
- R10: Reset gives 0xFFFF in both latch and count, a low flag, and one-shot mode disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| cont_mode | input | 1 | 1 = continuous reload, 0 = one-shot |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (for read side effects) |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the selected address |
| flag_clr | input | 1 | Flag clear strobe |
| irq_flag | output | 1 | Timer flag level |
| flag_set | output | 1 | One-cycle pulse when the flag is raised |

## Verification
The hardest state to reach is in one-shot mode: a second zero crossing that must stay silent. That takes a full run of the counter from 0xFFFE back to zero, which the stimulus provides with one long burst of tick cycles after the first flag has been cleared.

The same applies to reset. The stimulus checks that reset leaves one-shot mode disarmed by letting the reset value of 0xFFFF count all the way to zero with no load.

The edge where a zero event and a clear strobe coincide is reached by parking the count at 1 and then raising both inputs together.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_LAT_LO = 2'd2,
    SEL_LAT_HI = 2'd3
  } reg_sel_e;

  // Low latch lane is written from either low address
  function automatic logic hits_low_lane(input logic [1:0] a);
    return (a == SEL_CNT_LO) || (a == SEL_LAT_LO);
  endfunction

  // High latch lane is written from either high address
  function automatic logic hits_high_lane(input logic [1:0] a);
    return (a == SEL_CNT_HI) || (a == SEL_LAT_HI);
  endfunction

endpackage

// File: rtl/tmr16_latch.sv
module tmr16_latch #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned VAL_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [VAL_W-1:0]  latch_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        latch_q[g*BYTE_W +: BYTE_W] <= '1;
      else if (lane_wr[g])
        latch_q[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch,
  input  logic             continuous,
  output logic [CNT_W-1:0] count_q,
  output logic             zero_evt
);

  logic             wrapped_q;
  logic             armed_q;
  logic [CNT_W-1:0] next_cnt;

  // After passing 0 -> all-ones, continuous mode reloads; otherwise decrement
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic             was_wrapped,
    input logic             cont,
    input logic [CNT_W-1:0] lat
  );
    if (was_wrapped && cont)
      return lat;
    return cur - 1'b1;
  endfunction

  always_comb begin
    next_cnt = step_count(count_q, wrapped_q, continuous, latch);
    zero_evt = tick && !load && (next_cnt == '0) && (continuous || armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '1;
      wrapped_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (load) begin
      count_q   <= load_val;
      wrapped_q <= 1'b0;
      armed_q   <= 1'b1;
    end else if (tick) begin
      count_q   <= next_cnt;
      wrapped_q <= (count_q == '0);
      if (next_cnt == '0)
        armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q,
  output logic set_pulse_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q      <= 1'b0;
      set_pulse_q <= 1'b0;
    end else begin
      set_pulse_q <= set_evt;
      if (set_evt)
        flag_q <= 1'b1;
      else if (clr_req)
        flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/latched_timer16.sv
module latched_timer16 #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cont_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              flag_clr,
  output logic              irq_flag,
  output logic              flag_set
);
  import tmr16_pkg::*;

  logic [1:0]       lane_wr;
  logic             load_req;
  logic             clr_req;
  logic             zero_evt;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    lane_wr[0] = host_wr && hits_low_lane(host_addr);
    lane_wr[1] = host_wr && hits_high_lane(host_addr);
    load_req   = host_wr && (host_addr == SEL_CNT_HI);
    load_val   = {host_wdata, latch_q[BYTE_W-1:0]};
    clr_req    = flag_clr
               || load_req
               || (host_wr && (host_addr == SEL_LAT_HI))
               || (host_rd && (host_addr == SEL_CNT_LO));
  end

  tmr16_latch #(.BYTE_W(BYTE_W), .LANES(2)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_wr (lane_wr),
    .wdata   (host_wdata),
    .latch_q (latch_q)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .load       (load_req),
    .load_val   (load_val),
    .latch      (latch_q),
    .continuous (cont_mode),
    .count_q    (count_q),
    .zero_evt   (zero_evt)
  );

  tmr16_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_evt     (zero_evt),
    .clr_req     (clr_req),
    .flag_q      (irq_flag),
    .set_pulse_q (flag_set)
  );

  always_comb begin
    unique case (host_addr)
      SEL_CNT_LO: host_rdata = count_q[BYTE_W-1:0];
      SEL_CNT_HI: host_rdata = count_q[CNT_W-1:BYTE_W];
      SEL_LAT_LO: host_rdata = latch_q[BYTE_W-1:0];
      default:    host_rdata = latch_q[CNT_W-1:BYTE_W];
    endcase
  end

endmodule

// File: rtl/latched_timer16_chk.sv
module latched_timer16_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch,
  input logic             flag,
  input logic             flag_set
);

  // R2: count-high write loads the latch and clears the flag
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1) |=> (count == latch) && !flag);

  // R3: latch-high write leaves the count alone and clears the flag
  assert_latch_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd3 && !tick_en) |=> $stable(count) && !flag);

  // R4: no tick and no load means no change of count
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(host_wr && host_addr == 2'd1)) |=> $stable(count));

  // R5: a tick at zero passes to all-ones
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && count == '0 && !(host_wr && host_addr == 2'd1)) |=> (count == '1));

  // R6: the set pulse coincides with a zero count and a raised flag
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> (flag && count == '0));

  // R7: reading the count high byte keeps the flag
  assert_rd_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd1 && flag && !flag_clr && !host_wr) |=> flag);

endmodule

bind latched_timer16 latched_timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .flag_clr  (flag_clr),
  .count     (count_q),
  .latch     (latch_q),
  .flag      (irq_flag),
  .flag_set  (flag_set)
);

// File: tb/latched_timer16_bench.sv
module latched_timer16_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cont_mode = 1'b1;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       flag_clr = 1'b0;
  logic       irq_flag;
  logic       flag_set;

  int n_checks = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  latched_timer16 u_latched_timer16 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cont_mode(cont_mode),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .flag_set(flag_set)
  );

  always @(negedge clk) if (flag_set) pulse_cnt++;

  // ops: 0 write, 1 read-and-compare, 2 ticks, 3 flag compare
  // fields: op[31:30] addr[29:28] req[27:24] arg[23:8] exp[7:0]
  localparam int NV = 34;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd1, 16'h0005, 8'h00},  // R1 count-low write -> latch low
    {2'd1, 2'd0, 4'd1, 16'h0000, 8'hFF},  // R1 count untouched
    {2'd1, 2'd2, 4'd1, 16'h0000, 8'h05},
    {2'd1, 2'd3, 4'd1, 16'h0000, 8'hFF},
    {2'd0, 2'd1, 4'd2, 16'h0000, 8'h00},  // R2 load 0x0005
    {2'd1, 2'd0, 4'd2, 16'h0000, 8'h05},
    {2'd1, 2'd1, 4'd2, 16'h0000, 8'h00},
    {2'd3, 2'd0, 4'd2, 16'h0000, 8'h00},
    {2'd2, 2'd0, 4'd4, 16'd4,    8'h00},  // R4
    {2'd1, 2'd0, 4'd4, 16'h0000, 8'h01},
    {2'd2, 2'd0, 4'd6, 16'd1,    8'h00},  // R6 reach zero
    {2'd3, 2'd0, 4'd6, 16'h0000, 8'h01},
    {2'd1, 2'd1, 4'd7, 16'h0000, 8'h00},  // R7 high read keeps flag
    {2'd3, 2'd0, 4'd7, 16'h0000, 8'h01},
    {2'd1, 2'd0, 4'd7, 16'h0000, 8'h00},  // R7 low read clears flag
    {2'd3, 2'd0, 4'd7, 16'h0000, 8'h00},
    {2'd2, 2'd0, 4'd5, 16'd1,    8'h00},  // R5 0 -> FFFF
    {2'd1, 2'd1, 4'd5, 16'h0000, 8'hFF},
    {2'd1, 2'd0, 4'd5, 16'h0000, 8'hFF},
    {2'd2, 2'd0, 4'd5, 16'd1,    8'h00},  // R5 reload
    {2'd1, 2'd0, 4'd5, 16'h0000, 8'h05},
    {2'd2, 2'd0, 4'd5, 16'd5,    8'h00},
    {2'd3, 2'd0, 4'd5, 16'h0000, 8'h01},
    {2'd0, 2'd3, 4'd3, 16'h0000, 8'h00},  // R3 latch-high write
    {2'd3, 2'd0, 4'd3, 16'h0000, 8'h00},
    {2'd1, 2'd0, 4'd3, 16'h0000, 8'h00},
    {2'd0, 2'd2, 4'd3, 16'h0002, 8'h00},  // R3 latch-low write
    {2'd1, 2'd2, 4'd3, 16'h0000, 8'h02},
    {2'd1, 2'd3, 4'd3, 16'h0000, 8'h00},
    {2'd1, 2'd0, 4'd3, 16'h0000, 8'h00},
    {2'd2, 2'd0, 4'd5, 16'd2,    8'h00},  // R5 reload of new latch
    {2'd1, 2'd0, 4'd5, 16'h0000, 8'h02},
    {2'd2, 2'd0, 4'd6, 16'd2,    8'h00},
    {2'd3, 2'd0, 4'd6, 16'h0000, 8'h01}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      do_rd(a[1:0], rv);
      check(10, rv, 8'hFF, "reset register value");
    end
    @(negedge clk);
    check(10, irq_flag, 1'b0, "reset flag");

    // vector table, continuous mode
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][31:30])
        2'd0: do_wr(VEC[i][29:28], VEC[i][15:8]);
        2'd1: begin
          do_rd(VEC[i][29:28], rv);
          check(int'(VEC[i][27:24]), rv, VEC[i][7:0], $sformatf("vector %0d read", i));
        end
        2'd2: do_tick(int'(VEC[i][23:8]));
        default: begin
          @(negedge clk);
          check(int'(VEC[i][27:24]), irq_flag, VEC[i][0], $sformatf("vector %0d flag", i));
        end
      endcase
    end

    // R4: idle cycles without tick hold the count; R2 load clears flag
    do_wr(2'd0, 8'h0A);
    do_wr(2'd1, 8'h00);
    check(2, irq_flag, 1'b0, "flag after load");
    repeat (5) @(negedge clk);
    do_rd(2'd0, rv);
    check(4, rv, 8'h0A, "count held without tick");

    // R9: set beats clear on the same edge, then strobe clears
    do_tick(9);
    @(negedge clk);
    tick_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; flag_clr = 1'b0;
    check(9, irq_flag, 1'b1, "set wins over clear");
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(9, irq_flag, 1'b0, "strobe clears flag");

    // R8 one-shot mode
    cont_mode = 1'b0;
    do_wr(2'd0, 8'h03);
    do_wr(2'd1, 8'h00);
    pulse_cnt = 0;
    do_tick(3);
    check(8, irq_flag, 1'b1, "one-shot first zero");
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(9, irq_flag, 1'b0, "strobe clears one-shot flag");
    do_tick(1);
    do_rd(2'd0, rv);
    check(8, rv, 8'hFF, "one-shot passes to FFFF");
    do_tick(1);
    do_rd(2'd0, rv);
    check(8, rv, 8'hFE, "one-shot no reload");
    do_tick(65534);
    do_rd(2'd1, rv);
    check(8, rv, 8'h00, "one-shot second zero high byte");
    do_rd(2'd0, rv);
    check(8, rv, 8'h00, "one-shot second zero low byte");
    @(negedge clk);
    check(8, irq_flag, 1'b0, "no flag on second zero");
    check(6, pulse_cnt[15:0], 16'd1, "exactly one set pulse");

    // R10 reset leaves one-shot disarmed
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_rd(2'd1, rv);
    check(10, rv, 8'hFF, "count after reset");
    do_tick(65535);
    do_rd(2'd1, rv);
    check(10, rv, 8'h00, "counted to zero after reset");
    @(negedge clk);
    check(10, irq_flag, 1'b0, "disarmed after reset");

    finish_run();
  end

endmodule